// File: doc/BRIEF.md
# Branch trace capture queue

This debug block records each discontinuity in program flow as a pair of addresses: where control left and where it arrived. The pairs go into a small queue whose head is always the most recent capture. A new capture pushes older pairs one place deeper, and once the queue is full the oldest pair falls off the end. Capture runs only while a trace-enable input is high.

The execution pipeline reports at most one event per cycle, together with a kind code. For an ordinary branch the block takes the branch instruction's address and the target address. For an interrupt or exception it takes the PC value saved by the exception and the handler start address instead. Wraps of the DSP hardware repeat loop are not branches and are dropped, as is the reserved kind code.

Software drains the queue through two read strobes, one for a source port and one for a destination port. Both ports look at the same head entry. Only a destination read removes the head, so software reads source first and then destination. A rising edge on trace-enable marks every entry invalid, which means that turning trace off and back on always starts from an empty queue.

Top module: `brtrace_queue`

## Requirements
- R1: After synchronous reset every entry is invalid, both read data outputs are zero, and trace is treated as previously disabled.
- R2: A pair is captured only in a cycle where trace_en is 1 and ev_valid is 1. Events in other cycles leave the queue unchanged, and entries captured earlier stay readable while trace_en is 0.
- R3: For ev_kind 0 (branch) the source entry takes br_src and the destination entry takes br_dst.
- R4: For ev_kind 1 (interrupt/exception) the source entry takes exc_spc and the destination entry takes exc_vec.
- R5: ev_kind 2 (repeat-loop wrap) and ev_kind 3 (reserved) are never recorded.
- R6: A read strobe loads its port's data output at the next clock edge, and the output holds its value until the next strobe on that port. The data word is the head address with bit 0 forced to 1 when the head is valid, or all zeros when the head is invalid. Bit 0 acts as the valid flag and replaces address bit 0, because instruction addresses are halfword aligned.
- R7: rd_src does not move the shared pointer, so repeated source reads return the same head. rd_dst pops the head, and the next older pair becomes the head.
- R8: The queue holds DEPTH pairs (8 by default), with the newest at the head. A capture while the queue is full discards the oldest pair.
- R9: When a capture and rd_dst fall in the same cycle, the read returns the old head, the old head is popped, and the new pair becomes the head. No other entry is lost or duplicated.
- R10: In any cycle where trace_en is 1 and was 0 in the previous cycle, every entry is invalidated. An event captured in that same cycle survives as the only entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Trace enable; a rising edge clears the queue |
| ev_valid | input | 1 | Flow event present this cycle |
| ev_kind | input | 2 | 0 branch, 1 interrupt/exception, 2 repeat wrap, 3 reserved |
| br_src | input | AW | Address of the branch instruction |
| br_dst | input | AW | Branch target address |
| exc_spc | input | AW | PC value saved by the exception |
| exc_vec | input | AW | Handler start address |
| rd_src | input | 1 | Read strobe for the source port |
| rd_dst | input | 1 | Read strobe for the destination port; pops the head |
| src_rdata | output | AW | Source port data: address with valid flag in bit 0 |
| dst_rdata | output | AW | Destination port data: address with valid flag in bit 0 |

## Verification
The assertions check every cycle that the valid flags stay packed toward the head. They also check that a push, a pop, a combined push-and-pop and an enable-edge clear each move the flags and the head entry as R7 through R10 require. Further per-cycle checks cover that a repeat-loop wrap never disturbs the head, and that read outputs hold between strobes and read as zero on an empty head. The choice of source or destination operand for each event kind, the age ordering across a full drain, the overflow discard, and retention of entries while trace is off all depend on sequences of captures and reads. Only the bench's scenarios can show those.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  typedef enum logic [1:0] {
    K_BRANCH = 2'd0,
    K_EXCEPT = 2'd1,
    K_REPEAT = 2'd2,
    K_RSVD   = 2'd3
  } ev_kind_t;
endpackage

// File: rtl/brtrace_filter.sv
module brtrace_filter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trace_en,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_dst,
  input  logic [AW-1:0] exc_spc,
  input  logic [AW-1:0] exc_vec,
  output logic          cap,
  output logic [AW-1:0] cap_src,
  output logic [AW-1:0] cap_dst,
  output logic          clr
);
  import brtrace_pkg::*;

  logic     en_q;
  ev_kind_t kind;

  assign kind = ev_kind_t'(ev_kind);

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= trace_en;
  end

  // enable edge: off in the previous cycle, on now
  assign clr = trace_en & ~en_q;

  always_comb begin
    cap     = 1'b0;
    cap_src = br_src;
    cap_dst = br_dst;
    if (trace_en && ev_valid) begin
      unique case (kind)
        K_BRANCH: begin
          cap     = 1'b1;
          cap_src = br_src;
          cap_dst = br_dst;
        end
        K_EXCEPT: begin
          cap     = 1'b1;
          cap_src = exc_spc;
          cap_dst = exc_vec;
        end
        default: cap = 1'b0;   // repeat wrap and reserved code dropped
      endcase
    end
  end

  // the enable edge can only follow a cycle with trace off
  p_edge_after_off_r10: assert property (@(posedge clk) disable iff (rst)
    clr |-> !$past(trace_en));
endmodule

// File: rtl/brtrace_shiftq.sv
module brtrace_shiftq #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] push_src,
  input  logic [AW-1:0] push_dst,
  input  logic          pop,
  output logic          head_vld,
  output logic [AW-1:0] head_src,
  output logic [AW-1:0] head_dst
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] q_v,  nx_v;
  logic [AW-1:0]    q_s  [DEPTH];
  logic [AW-1:0]    q_d  [DEPTH];
  logic [AW-1:0]    nx_s [DEPTH];
  logic [AW-1:0]    nx_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int up;
      int dn;
      up = (i == LAST) ? LAST : i + 1;
      dn = (i == 0) ? 0 : i - 1;
      nx_v[i] = q_v[i];
      nx_s[i] = q_s[i];
      nx_d[i] = q_d[i];
      if (clr) begin
        nx_v[i] = 1'b0;
      end else if (push && !pop) begin
        if (i == 0) begin
          nx_v[i] = 1'b1;
          nx_s[i] = push_src;
          nx_d[i] = push_dst;
        end else begin
          nx_v[i] = q_v[dn];
          nx_s[i] = q_s[dn];
          nx_d[i] = q_d[dn];
        end
      end else if (pop && !push) begin
        if (i == LAST) begin
          nx_v[i] = 1'b0;
        end else begin
          nx_v[i] = q_v[up];
          nx_s[i] = q_s[up];
          nx_d[i] = q_d[up];
        end
      end else if (push && pop && i == 0) begin
        nx_v[i] = 1'b1;
        nx_s[i] = push_src;
        nx_d[i] = push_dst;
      end
    end
    if (clr && push) begin
      nx_v[0] = 1'b1;
      nx_s[0] = push_src;
      nx_d[0] = push_dst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_v <= '0;
    else     q_v <= nx_v;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        q_s[g] <= nx_s[g];
        q_d[g] <= nx_d[g];
      end
    end
  endgenerate

  assign head_vld = q_v[0];
  assign head_src = q_s[0];
  assign head_dst = q_d[0];

  p_packed_valid_r8: assert property (@(posedge clk) disable iff (rst)
    ((q_v + 1'b1) & q_v) == '0);

  p_push_shift_r8: assert property (@(posedge clk) disable iff (rst)
    push && !pop && !clr |=> q_v == (($past(q_v) << 1) | 1'b1)
                             && q_s[0] == $past(push_src)
                             && q_d[0] == $past(push_dst));

  p_pop_shift_r7: assert property (@(posedge clk) disable iff (rst)
    pop && !push && !clr |=> q_v == ($past(q_v) >> 1));

  p_push_pop_r9: assert property (@(posedge clk) disable iff (rst)
    push && pop && !clr |=> q_v == ($past(q_v) | 1'b1)
                            && q_s[0] == $past(push_src));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> q_v == {{(DEPTH-1){1'b0}}, $past(push)});
endmodule

// File: rtl/brtrace_rdport.sv
module brtrace_rdport #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_src,
  input  logic          rd_dst,
  input  logic          head_vld,
  input  logic [AW-1:0] head_src,
  input  logic [AW-1:0] head_dst,
  output logic [AW-1:0] src_rdata,
  output logic [AW-1:0] dst_rdata
);
  localparam logic [AW-1:0] VBIT = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] word_s, word_d;

  assign word_s = head_vld ? (head_src | VBIT) : '0;
  assign word_d = head_vld ? (head_dst | VBIT) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_rdata <= '0;
      dst_rdata <= '0;
    end else begin
      if (rd_src) src_rdata <= word_s;
      if (rd_dst) dst_rdata <= word_d;
    end
  end

  p_hold_src_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_src |=> $stable(src_rdata));

  p_hold_dst_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_dst |=> $stable(dst_rdata));

  p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_dst && !head_vld |=> dst_rdata == '0);
endmodule

// File: rtl/brtrace_queue.sv
module brtrace_queue #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trace_en,
  input  logic          ev_valid,
  input  logic [1:0]    ev_kind,
  input  logic [AW-1:0] br_src,
  input  logic [AW-1:0] br_dst,
  input  logic [AW-1:0] exc_spc,
  input  logic [AW-1:0] exc_vec,
  input  logic          rd_src,
  input  logic          rd_dst,
  output logic [AW-1:0] src_rdata,
  output logic [AW-1:0] dst_rdata
);
  import brtrace_pkg::*;

  logic          cap, clr;
  logic [AW-1:0] cap_src, cap_dst;
  logic          head_vld;
  logic [AW-1:0] head_src, head_dst;

  brtrace_filter #(.AW(AW)) filt_i (
    .clk(clk), .rst(rst), .trace_en(trace_en), .ev_valid(ev_valid),
    .ev_kind(ev_kind), .br_src(br_src), .br_dst(br_dst),
    .exc_spc(exc_spc), .exc_vec(exc_vec),
    .cap(cap), .cap_src(cap_src), .cap_dst(cap_dst), .clr(clr)
  );

  brtrace_shiftq #(.AW(AW), .DEPTH(DEPTH)) q_i (
    .clk(clk), .rst(rst), .clr(clr), .push(cap),
    .push_src(cap_src), .push_dst(cap_dst), .pop(rd_dst),
    .head_vld(head_vld), .head_src(head_src), .head_dst(head_dst)
  );

  brtrace_rdport #(.AW(AW)) rd_i (
    .clk(clk), .rst(rst), .rd_src(rd_src), .rd_dst(rd_dst),
    .head_vld(head_vld), .head_src(head_src), .head_dst(head_dst),
    .src_rdata(src_rdata), .dst_rdata(dst_rdata)
  );

  p_repeat_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_kind == K_REPEAT && !rd_dst && !clr
      |=> $stable(head_vld) && $stable(head_src) && $stable(head_dst));

  p_disabled_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    !trace_en && !rd_dst |=> $stable(head_vld) && $stable(head_src));
endmodule

// File: tb/brtrace_queue_tb_top.sv
module brtrace_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trace_en = 1'b0, ev_valid = 1'b0, rd_src = 1'b0, rd_dst = 1'b0;
  logic [1:0]    ev_kind = 2'd0;
  logic [AW-1:0] br_src = '0, br_dst = '0, exc_spc = '0, exc_vec = '0;
  logic [AW-1:0] src_rdata, dst_rdata;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brtrace_queue #(.AW(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .trace_en(trace_en), .ev_valid(ev_valid),
    .ev_kind(ev_kind), .br_src(br_src), .br_dst(br_dst),
    .exc_spc(exc_spc), .exc_vec(exc_vec), .rd_src(rd_src), .rd_dst(rd_dst),
    .src_rdata(src_rdata), .dst_rdata(dst_rdata)
  );

  // bench reference of the queue, built from the requirements
  logic [AW-1:0] m_s [DEPTH];
  logic [AW-1:0] m_d [DEPTH];
  bit            m_v [DEPTH];
  bit            en_prev = 1'b0;
  logic [AW-1:0] last_s;

  typedef struct packed {
    logic          evv;
    logic [1:0]    kind;
    logic [AW-1:0] a, b, c, d;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b1, 2'd0, 32'h0000_1000, 32'h0000_2000, 32'h0000_0EEE, 32'h0000_0DDD},
    '{1'b1, 2'd1, 32'h0000_1111, 32'h0000_2222, 32'h0000_3004, 32'h0000_0100},
    '{1'b1, 2'd2, 32'h0000_4000, 32'h0000_4100, 32'h0000_4200, 32'h0000_4300},
    '{1'b0, 2'd0, 32'h0000_5000, 32'h0000_6000, 32'h0000_5100, 32'h0000_6100},
    '{1'b1, 2'd3, 32'h0000_5500, 32'h0000_6600, 32'h0000_5700, 32'h0000_6800},
    '{1'b1, 2'd0, 32'h0000_7000, 32'h0000_7100, 32'h0000_7200, 32'h0000_7300},
    '{1'b1, 2'd1, 32'h0000_7A00, 32'h0000_7B00, 32'h0000_8000, 32'h0000_8100},
    '{1'b1, 2'd0, 32'h0000_9002, 32'h0000_9200, 32'h0000_9300, 32'h0000_9400},
    '{1'b1, 2'd2, 32'h0000_9800, 32'h0000_9900, 32'h0000_9A00, 32'h0000_9B00},
    '{1'b1, 2'd0, 32'hA000_0000, 32'hA000_00FE, 32'hA000_0100, 32'hA000_0200}
  };

  function automatic logic [AW-1:0] mword(bit v, logic [AW-1:0] a);
    return v ? {a[AW-1:1], 1'b1} : '0;
  endfunction

  task automatic check(logic [AW-1:0] act, logic [AW-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, model the rising edge, sample at the next falling edge
  task automatic cyc(bit en, bit evv, logic [1:0] kind,
                     logic [AW-1:0] a, logic [AW-1:0] b,
                     logic [AW-1:0] c, logic [AW-1:0] d,
                     bit rs, bit rd, string req);
    logic [AW-1:0] ew_s, ew_d, ns, nd;
    bit clr, cap;
    ew_s = mword(m_v[0], m_s[0]);
    ew_d = mword(m_v[0], m_d[0]);
    trace_en = en; ev_valid = evv; ev_kind = kind;
    br_src = a; br_dst = b; exc_spc = c; exc_vec = d;
    rd_src = rs; rd_dst = rd;
    @(negedge clk);
    clr = en && !en_prev;
    en_prev = en;
    cap = en && evv && (kind == 2'd0 || kind == 2'd1);
    ns = (kind == 2'd0) ? a : c;
    nd = (kind == 2'd0) ? b : d;
    if (rd) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_s[i] = m_s[i+1]; m_d[i] = m_d[i+1]; m_v[i] = m_v[i+1];
      end
      m_v[DEPTH-1] = 1'b0;
    end
    if (clr) for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    if (cap) begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        m_s[i] = m_s[i-1]; m_d[i] = m_d[i-1]; m_v[i] = m_v[i-1];
      end
      m_s[0] = ns; m_d[0] = nd; m_v[0] = 1'b1;
    end
    if (rs) begin
      check(src_rdata, ew_s, req);
      last_s = ew_s;
    end
    if (rd) check(dst_rdata, ew_d, req);
    rd_src = 1'b0; rd_dst = 1'b0; ev_valid = 1'b0;
  endtask

  task automatic idle(bit en);
    cyc(en, 1'b0, 2'd0, '0, '0, '0, '0, 1'b0, 1'b0, "idle");
  endtask

  task automatic read_pair(bit en, string req);
    cyc(en, 1'b0, 2'd0, '0, '0, '0, '0, 1'b1, 1'b0, req);
    cyc(en, 1'b0, 2'd0, '0, '0, '0, '0, 1'b0, 1'b1, req);
  endtask

  task automatic branch(logic [AW-1:0] s, logic [AW-1:0] d);
    cyc(1'b1, 1'b1, 2'd0, s, d, '0, '0, 1'b0, 1'b0, "push");
  endtask

  task automatic drain(bit en, string req);
    for (int i = 0; i < DEPTH + 1; i++) read_pair(en, req);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_s[i] = '0; m_d[i] = '0; m_v[i] = 1'b0;
    end
    last_s = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(src_rdata, '0, "R1 src after reset");
    check(dst_rdata, '0, "R1 dst after reset");
    read_pair(1'b0, "R1 empty queue reads zero");

    // table walk: branch, exception, repeat, not valid, reserved (R2 R3 R4 R5)
    idle(1'b1);
    for (int i = 0; i < 10; i++)
      cyc(1'b1, TBL[i].evv, TBL[i].kind, TBL[i].a, TBL[i].b, TBL[i].c, TBL[i].d,
          1'b0, 1'b0, "table");
    drain(1'b1, "R3/R4/R5/R2 table drain");

    // R8: overflow keeps the newest DEPTH pairs
    for (int i = 0; i < DEPTH + 2; i++)
      branch(32'h0001_0000 + 32'(i * 16), 32'h0002_0000 + 32'(i * 16));
    drain(1'b1, "R8 overflow order");

    // R7: source reads alone do not advance
    branch(32'h0000_3330, 32'h0000_4440);
    branch(32'h0000_5550, 32'h0000_6660);
    cyc(1'b1, 1'b0, 2'd0, '0, '0, '0, '0, 1'b1, 1'b0, "R7 src read 1");
    cyc(1'b1, 1'b0, 2'd0, '0, '0, '0, '0, 1'b1, 1'b0, "R7 src read 2");
    check(src_rdata, 32'h0000_5551, "R7 head unchanged by src read");
    drain(1'b1, "R7 pair reads");

    // R6: valid flag in bit 0, output held between strobes
    branch(32'h0000_1235, 32'h0000_1300);
    cyc(1'b1, 1'b0, 2'd0, '0, '0, '0, '0, 1'b1, 1'b0, "R6 word format");
    check(src_rdata, 32'h0000_1235, "R6 flag replaces bit 0");
    idle(1'b1); idle(1'b1);
    check(src_rdata, last_s, "R6 held without strobe");
    drain(1'b1, "R6 drain");

    // R2: trace off ignores events, keeps stored pairs readable
    branch(32'h0000_7770, 32'h0000_7780);
    cyc(1'b0, 1'b1, 2'd0, 32'h0000_DEAD, 32'h0000_BEEF, '0, '0, 1'b0, 1'b0, "off event");
    cyc(1'b0, 1'b1, 2'd1, '0, '0, 32'h0000_CAF0, 32'h0000_F00C, 1'b0, 1'b0, "off exc");
    read_pair(1'b0, "R2 stored pair while off");
    read_pair(1'b0, "R2 nothing captured while off");

    // R10: off/on toggle invalidates everything
    idle(1'b1);
    branch(32'h0000_A100, 32'h0000_A200);
    branch(32'h0000_A300, 32'h0000_A400);
    idle(1'b0);
    idle(1'b1);
    read_pair(1'b1, "R10 cleared by enable edge");

    // R10: capture in the enable-edge cycle survives alone
    branch(32'h0000_B100, 32'h0000_B200);
    idle(1'b0);
    cyc(1'b1, 1'b1, 2'd1, '0, '0, 32'h0000_C100, 32'h0000_C200, 1'b0, 1'b0, "edge capture");
    read_pair(1'b1, "R10 edge-cycle capture kept");
    read_pair(1'b1, "R10 older pair gone");

    // R9: capture together with destination read
    branch(32'h0000_D100, 32'h0000_D200);
    branch(32'h0000_D300, 32'h0000_D400);
    branch(32'h0000_D500, 32'h0000_D600);
    cyc(1'b1, 1'b1, 2'd0, 32'h0000_E100, 32'h0000_E200, '0, '0, 1'b0, 1'b1, "R9 read old head");
    drain(1'b1, "R9 after push and pop");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule